// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog Reset

This block is a 32-bit free-running counter with four compare channels. It sits on a simple word-addressed register bus. The counter advances by one on each cycle in which the slow timer tick enable is high. The tick is a synchronous enable inside the bus clock domain.

Each channel has a 32-bit compare value. When the counter steps onto that value and the channel's interrupt enable is set, the channel's status flag is raised. A flag stays up until software writes a one to it. The per-channel interrupt lines and a combined interrupt line follow the flags, masked by the enables.

Channel 3 also serves as a watchdog. Once software arms the sticky watchdog enable, a channel-3 compare hit sends a one-cycle reset request. Only a block reset can disarm the watchdog. A software write to the counter does not take effect at once: the new value is loaded on the second tick after the write. Software polls the counter until the read value matches.

Top module: `cmp_timer_wdog`

## Requirements
- R1: After reset, the counter, the status flags, the watchdog enable, the interrupt enables and all four compare values read zero. `irq_o`, `irq_any_o` and `wdog_rst_o` are low.
- R2: The counter steps by one at each clock edge where `tick_i` is high, and holds its value when `tick_i` is low. It wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter (offset 0x10) is loaded at the second tick edge after the write. At the first tick edge the counter still steps from its old value.
- R4: Compare channels 0 to 3 are read/write at offsets 0x00, 0x04, 0x08 and 0x0C. The interrupt enable register at 0x1C keeps bits 3:0 only, bit k for channel k, and its upper bits read zero.
- R5: Status bit k (offset 0x14, bit k) is set at the tick edge where the counter takes the value of compare k. This happens only if enable bit k is set.
- R6: Writing a one to a status bit clears it. Writing a zero leaves it unchanged. Status bits 31:4 read zero.
- R7: If a clearing write and a new compare hit reach the same channel in the same cycle, the status bit stays set.
- R8: `irq_o[k]` equals status bit k AND enable bit k. `irq_any_o` is the OR of the four.
- R9: The watchdog enable (offset 0x18, bit 0) is set by writing a one. Writing a zero does not clear it, and only reset does.
- R10: With the watchdog enable set, a channel-3 hit drives `wdog_rst_o` high for exactly the cycle after that tick edge. With the enable clear, `wdog_rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable, one cycle per count step |
| addr_i | input | 5 | Byte address, word aligned |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 4 | Per-channel interrupts |
| irq_any_o | output | 1 | OR of all channel interrupts |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The assertions check four things on every cycle:
- the counter holds when there is no tick and steps by one on an unloaded tick;
- a qualified hit always leaves its flag set, even against a clearing write;
- a flag never rises without a qualified hit;
- the watchdog enable never falls, and no reset request appears while the watchdog is disarmed.

The bench scenarios show the behaviours that depend on values and timing. These are the exact tick at which a delayed counter write lands, the wrap from all-ones, and masked channels staying quiet. They also include the register read-back masks and the single reset pulse when the counter reaches compare 3.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 5;

  // word index = addr[4:2]
  typedef enum logic [2:0] {
    W_CMP0 = 3'd0,
    W_CMP1 = 3'd1,
    W_CMP2 = 3'd2,
    W_CMP3 = 3'd3,
    W_CNT  = 3'd4,
    W_STS  = 3'd5,
    W_WDEN = 3'd6,
    W_IEN  = 3'd7
  } word_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned LOAD_TICKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam int unsigned PW = (LOAD_TICKS > 2) ? $clog2(LOAD_TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(LOAD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, pval_q;
  logic             pend_q;
  logic [PW-1:0]    pcnt_q;
  logic             load_now;

  assign load_now  = pend_q && (pcnt_q == LAST);
  assign cnt_nxt_o = load_now ? pval_q : cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pval_q <= '0;
      pend_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (tick_i) cnt_q <= cnt_nxt_o;
      if (ld_i) begin
        pend_q <= 1'b1;
        pcnt_q <= '0;
        pval_q <= ld_val_i;
      end else if (tick_i && pend_q) begin
        if (load_now) pend_q <= 1'b0;
        else          pcnt_q <= pcnt_q + PW'(1);
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_now) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ien_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o,
  output logic             sts_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             sts_q;
  logic             set;

  assign hit_o = tick_i && (cnt_nxt_i == cmp_q);
  assign set   = hit_o && ien_i;
  assign cmp_o = cmp_q;
  assign sts_o = sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= wdata_i;
      sts_q <= set | (sts_q & ~clr_i);  // new hit beats clear
    end
  end

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && ien_i) |=> sts_q);
  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && ien_i && clr_i) |=> sts_q);
  p_no_spur_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_q && !(hit_o && ien_i)) |=> !sts_q);
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && clr_i && !(hit_o && ien_i)) |=> !sts_q);
endmodule

// File: rtl/cmp_timer_wdog.sv
module cmp_timer_wdog
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned LOAD_TICKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [NCH-1:0]   irq_o,
  output logic             irq_any_o,
  output logic             wdog_rst_o
);
  logic             aligned;
  word_e            widx;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [CNT_W-1:0] cmp [NCH];
  logic [NCH-1:0]   hit, sts, ien_q;
  logic             wden_q, wrst_q;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign widx    = word_e'(addr_i[4:2]);

  tmr_count #(.CNT_W(CNT_W), .LOAD_TICKS(LOAD_TICKS)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .ld_i      (we_i && aligned && widx == W_CNT),
    .ld_val_i  (wdata_i),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .cnt_nxt_i (cnt_nxt),
      .cmp_we_i  (we_i && aligned && widx == word_e'(k)),
      .wdata_i   (wdata_i),
      .ien_i     (ien_q[k]),
      .clr_i     (we_i && aligned && widx == W_STS && wdata_i[k]),
      .cmp_o     (cmp[k]),
      .hit_o     (hit[k]),
      .sts_o     (sts[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      wden_q <= 1'b0;
      wrst_q <= 1'b0;
    end else begin
      if (we_i && aligned && widx == W_IEN) ien_q <= wdata_i[NCH-1:0];
      if (we_i && aligned && widx == W_WDEN && wdata_i[0]) wden_q <= 1'b1;
      wrst_q <= wden_q && hit[3];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (widx)
        W_CMP0, W_CMP1, W_CMP2, W_CMP3: rdata_o = cmp[addr_i[3:2]];
        W_CNT:  rdata_o = cnt;
        W_STS:  rdata_o[NCH-1:0] = sts;
        W_WDEN: rdata_o[0] = wden_q;
        W_IEN:  rdata_o[NCH-1:0] = ien_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o      = sts & ien_q;
  assign irq_any_o  = |irq_o;
  assign wdog_rst_o = wrst_q;

  p_wden_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wden_q |=> wden_q);
  p_no_rst_disarmed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wden_q |=> !wdog_rst_o);
  p_rst_after_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> $past(tick_i));
  p_irq_any_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o |-> (irq_o != '0));
endmodule

// File: tb/cmp_timer_wdog_test.sv
module cmp_timer_wdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        irq_any, wrst;

  int n_chk = 0, n_bad = 0, n_pulse = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_timer_wdog uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_any_o(irq_any),
    .wdog_rst_o(wrst)
  );

  always @(negedge clk) if (rst_n && wrst) n_pulse++;

  // {we, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'h00, 32'h0000_0010, 32'h0},
    {1'b0, 5'h00, 32'h0,         32'h0000_0010},
    {1'b1, 5'h04, 32'h0000_0020, 32'h0},
    {1'b0, 5'h04, 32'h0,         32'h0000_0020},
    {1'b1, 5'h08, 32'hAAAA_5555, 32'h0},
    {1'b0, 5'h08, 32'h0,         32'hAAAA_5555},
    {1'b1, 5'h0C, 32'h0000_0040, 32'h0},
    {1'b0, 5'h0C, 32'h0,         32'h0000_0040},
    {1'b1, 5'h1C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 5'h1C, 32'h0,         32'h0000_000F},
    {1'b1, 5'h1C, 32'h0000_0005, 32'h0},
    {1'b0, 5'h1C, 32'h0,         32'h0000_0005},
    {1'b1, 5'h14, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 5'h14, 32'h0,         32'h0},
    {1'b0, 5'h18, 32'h0,         32'h0},
    {1'b0, 5'h10, 32'h0,         32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v); chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 outputs", {29'h0, irq_any, wrst, |irq}, 32'h0);
    rst_n = 1'b1;
    // R4 R6 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      else begin
        @(negedge clk); rd(VEC[i][68:64], v);
        chk("R4/R6 table", v, VEC[i][31:0]);
      end
    end
    // R2 stepping and holding
    ticks(3); rd(5'h10, v); chk("R2 step", v, 32'd3);
    repeat (5) @(negedge clk); rd(5'h10, v); chk("R2 hold", v, 32'd3);
    // R5 R8 enabled channel 0 hit
    ticks(13); rd(5'h14, v); chk("R5 ch0 set", v, 32'h1);
    chk("R8 irq", {27'h0, irq_any, irq}, {27'h0, 1'b1, 4'b0001});
    // R5 masked channel 1 stays clear
    ticks(16); rd(5'h10, v); chk("R2 count", v, 32'h20);
    rd(5'h14, v); chk("R5 ch1 masked", v, 32'h1);
    // R6 zero write keeps, one write clears
    wr(5'h14, 32'h0); rd(5'h14, v); chk("R6 zero keeps", v, 32'h1);
    wr(5'h14, 32'h1); rd(5'h14, v); chk("R6 one clears", v, 32'h0);
    chk("R8 irq clear", {31'h0, irq_any}, 32'h0);
    // R7 clear and hit together
    wr(5'h1C, 32'hF); wr(5'h04, 32'h22);
    ticks(1);
    @(negedge clk); we = 1'b1; addr = 5'h14; wdata = 32'h2; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(5'h14, v); chk("R7 hit beats clear", v, 32'h2);
    wr(5'h14, 32'h2); rd(5'h14, v); chk("R7 later clear", v, 32'h0);
    // R10 disarmed: channel 3 hit, no reset request
    ticks(30); rd(5'h14, v); chk("R5 ch3 set", v, 32'h8);
    chk("R10 no pulse disarmed", n_pulse, 0);
    wr(5'h14, 32'h8);
    // R9 sticky watchdog enable
    wr(5'h18, 32'h0); rd(5'h18, v); chk("R9 zero no set", v, 32'h0);
    wr(5'h18, 32'h1); rd(5'h18, v); chk("R9 set", v, 32'h1);
    wr(5'h18, 32'h0); rd(5'h18, v); chk("R9 sticky", v, 32'h1);
    // R3 delayed counter load
    wr(5'h10, 32'h3E);
    rd(5'h10, v); chk("R3 not yet", v, 32'h40);
    ticks(1); rd(5'h10, v); chk("R3 first tick", v, 32'h41);
    ticks(1); rd(5'h10, v); chk("R3 loaded", v, 32'h3E);
    // R10 armed pulse
    ticks(1);
    ticks(1); chk("R10 pulse", {31'h0, wrst}, 32'h1);
    @(negedge clk); chk("R10 pulse ends", {31'h0, wrst}, 32'h0);
    chk("R10 pulse count", n_pulse, 1);
    // R2 wrap
    wr(5'h10, 32'hFFFF_FFFE); ticks(2);
    rd(5'h10, v); chk("R3 load wrap", v, 32'hFFFF_FFFE);
    ticks(1); rd(5'h10, v); chk("R2 all ones", v, 32'hFFFF_FFFF);
    ticks(1); rd(5'h10, v); chk("R2 wrap", v, 32'h0);
    // R9 R1 reset clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd(5'h18, v); chk("R9 reset clears", v, 32'h0);
    rd(5'h14, v); chk("R1 status reset", v, 32'h0);
    rd(5'h0C, v); chk("R1 cmp reset", v, 32'h0);
    rst_n = 1'b1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule